// File: doc/BRIEF.md
# Compacted Processor-State Save Sequencer

This block produces the memory writes of a compacting extended-state save. A single-cycle start pulse supplies these inputs:

- two 64-bit mask registers, of which only the low 32 bits of each are used;
- the feature-enable register;
- the in-use tracking bitmap;
- the current SSE control/status word;
- a 64-byte-aligned base address.

The block works out which of three modelled state components to store: component 0 (x87), component 1 (SSE) and component 2 (upper halves of the 256-bit vector registers). It then streams each stored component, one 64-bit beat per cycle, to a plain write port. The beat data comes from an abstract register-file read port that the block addresses by component and beat number.

After the component data the block writes two header words. The first is a bitmap of the components that hold live state. The second is a bitmap of the requested components, with bit 63 set to flag the compacted layout. The block then pulses done. Every other location in the save area is left untouched. Fault checks, paging and segmentation are the job of the surrounding pipeline.

Top module: `xsv_save_seq`

## Requirements
- R1: The request bitmap is `feat_en_i & {mask_hi_i[31:0], mask_lo_i[31:0]}`. Bits 63:32 of `mask_hi_i` and of `mask_lo_i` have no effect on any write.
- R2: Component 0 and component 2 are each stored only when both their request bit and their in-use bit are 1. A component that is not stored produces no write beats.
- R3: Component 1 is stored when its request bit is 1 and either its in-use bit is 1 or `mxcsr_i` differs from 32'h1F80.
- R4: The live-state header word is written to `base + 512` with the value `in_use_i & request`.
- R5: The format header word is written to `base + 520` with bit 63 set to 1 and bits 62:0 equal to request bits 62:0.
- R6: Beat k of a component is written to `base + offset + 8*k`, with data `rd_data_i` sampled in the same cycle while `rd_sel_o`/`rd_beat_o` equal the component index and k. The layout is:
  - x87: offset 0, 20 beats;
  - SSE: offset 160, 32 beats;
  - vector upper halves: offset 576, 32 beats.
- R7: Writes start in the cycle after the accepting edge and follow one per cycle with no gap. Components are written in ascending index order, then the live-state header word, then the format header word. `done_o` is high for exactly one cycle, the cycle after the last write. `busy_o` is high from the first write through the last write.
- R8: No write ever lands at an offset in 464..511 or 528..575 from the base.
- R9: A start pulse while `busy_o` is high is ignored. Inputs that change after the accepting edge do not alter the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| mask_hi_i | input | 64 | High mask register; bits 31:0 give request bits 63:32 |
| mask_lo_i | input | 64 | Low mask register; bits 31:0 give request bits 31:0 |
| feat_en_i | input | 64 | Feature-enable register |
| in_use_i | input | 64 | In-use tracking bitmap |
| mxcsr_i | input | 32 | Current SSE control/status word |
| base_i | input | ADDR_W | Base byte address of the save area |
| rd_sel_o | output | 2 | Component being read |
| rd_beat_o | output | 6 | Beat index within the component |
| rd_data_i | input | 64 | Register-file read data for the addressed beat |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | ADDR_W | Byte address of the write |
| wr_data_o | output | 64 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the SSE override: a component that is written while its live-state header bit stays 0. The stimulus reaches it by clearing every in-use bit, requesting SSE and supplying a non-default control word. It then repeats the run with the default word to show the beats disappear. A second awkward case is a start pulse, together with new inputs, arriving in the middle of a data stream. The bench raises one three cycles into a run and checks that the complete write list still matches the first operation.

// File: rtl/xsv_pkg.sv
package xsv_pkg;
  localparam int NCOMP      = 3;
  localparam int CW         = 2;
  localparam int BEAT_W     = 6;
  localparam int BEAT_BYTES = 8;
  localparam int HDR_OFF    = 512;
  localparam int HCOMP_OFF  = 520;
  localparam int GAP_LO     = 464;
  localparam int HDR_END    = 528;
  localparam int EXT_OFF    = 576;

  typedef enum logic [1:0] {ST_IDLE, ST_COMP, ST_XSTATE, ST_XCOMP} st_e;
  typedef enum logic [1:0] {WK_NONE, WK_COMP, WK_XSTATE, WK_XCOMP} wr_kind_e;

  function automatic int comp_beats(int idx);
    case (idx)
      0:       return 20;
      default: return 32;
    endcase
  endfunction

  function automatic int comp_off(int idx);
    case (idx)
      0:       return 0;
      1:       return 160;
      default: return EXT_OFF;
    endcase
  endfunction
endpackage

// File: rtl/xsv_select.sv
module xsv_select
  import xsv_pkg::*;
#(
  parameter logic [31:0] MXCSR_DEF = 32'h1F80
) (
  input  logic [63:0]      mask_hi_i,
  input  logic [63:0]      mask_lo_i,
  input  logic [63:0]      feat_en_i,
  input  logic [63:0]      in_use_i,
  input  logic [31:0]      mxcsr_i,
  output logic [NCOMP-1:0] save_o,
  output logic [63:0]      xstate_o,
  output logic [63:0]      xcomp_o
);
  logic [63:0] rfbm;
  logic        unused_upper;

  assign rfbm         = feat_en_i & {mask_hi_i[31:0], mask_lo_i[31:0]};
  assign unused_upper = ^{mask_hi_i[63:32], mask_lo_i[63:32]};

  for (genvar g = 0; g < NCOMP; g++) begin : g_save
    if (g == 1) begin : g_sse
      // non-default control word forces the save
      assign save_o[g] = rfbm[g] & (in_use_i[g] | (mxcsr_i != MXCSR_DEF));
    end else begin : g_plain
      assign save_o[g] = rfbm[g] & in_use_i[g];
    end
  end

  assign xstate_o = in_use_i & rfbm;
  assign xcomp_o  = {1'b1, rfbm[62:0]};
endmodule

// File: rtl/xsv_walker.sv
module xsv_walker
  import xsv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NCOMP-1:0]  save_i,
  output logic              busy_o,
  output wr_kind_e          kind_o,
  output logic [CW-1:0]     comp_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              done_o
);
  st_e               st_q;
  logic [CW-1:0]     comp_q;
  logic [BEAT_W-1:0] beat_q;
  logic [NCOMP-1:0]  save_q;
  logic              done_q;

  logic [NCOMP-1:0]  src;
  int                lo;
  logic              nf;
  logic [CW-1:0]     ni;
  logic              last_beat;

  // lowest stored component at or above lo
  always_comb begin
    src = (st_q == ST_IDLE) ? save_i : save_q;
    lo  = (st_q == ST_IDLE) ? 0 : int'(comp_q) + 1;
    nf  = 1'b0;
    ni  = '0;
    for (int i = NCOMP - 1; i >= 0; i--) begin
      if (i >= lo && src[i]) begin
        nf = 1'b1;
        ni = CW'(i);
      end
    end
  end

  assign last_beat = (int'(beat_q) == comp_beats(int'(comp_q)) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      comp_q <= '0;
      beat_q <= '0;
      save_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          save_q <= save_i;
          beat_q <= '0;
          if (nf) begin
            st_q   <= ST_COMP;
            comp_q <= ni;
          end else begin
            st_q <= ST_XSTATE;
          end
        end
        ST_COMP: if (last_beat) begin
          beat_q <= '0;
          if (nf) comp_q <= ni;
          else    st_q   <= ST_XSTATE;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
        ST_XSTATE: st_q <= ST_XCOMP;
        default: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_COMP:   kind_o = WK_COMP;
      ST_XSTATE: kind_o = WK_XSTATE;
      ST_XCOMP:  kind_o = WK_XCOMP;
      default:   kind_o = WK_NONE;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign comp_o = comp_q;
  assign beat_o = beat_q;
  assign done_o = done_q;

  // R7
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  hdr_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_XCOMP) |=> (done_q && st_q == ST_IDLE));
  // R7
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COMP && $past(st_q) == ST_COMP && comp_q != $past(comp_q))
      |-> (comp_q > $past(comp_q)));
  // R6
  beat_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COMP) |-> (int'(beat_q) < comp_beats(int'(comp_q))));
endmodule

// File: rtl/xsv_save_seq.sv
module xsv_save_seq
  import xsv_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       mask_hi_i,
  input  logic [63:0]       mask_lo_i,
  input  logic [63:0]       feat_en_i,
  input  logic [63:0]       in_use_i,
  input  logic [31:0]       mxcsr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [CW-1:0]     rd_sel_o,
  output logic [BEAT_W-1:0] rd_beat_o,
  input  logic [63:0]       rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [63:0]       wr_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [NCOMP-1:0]  save_c;
  logic [63:0]       xstate_c, xcomp_c;
  logic [63:0]       xstate_q, xcomp_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] off;
  wr_kind_e          kind;
  logic              accept;

  xsv_select u_select (
    .mask_hi_i (mask_hi_i),
    .mask_lo_i (mask_lo_i),
    .feat_en_i (feat_en_i),
    .in_use_i  (in_use_i),
    .mxcsr_i   (mxcsr_i),
    .save_o    (save_c),
    .xstate_o  (xstate_c),
    .xcomp_o   (xcomp_c)
  );

  xsv_walker u_walker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .save_i  (save_c),
    .busy_o  (busy_o),
    .kind_o  (kind),
    .comp_o  (rd_sel_o),
    .beat_o  (rd_beat_o),
    .done_o  (done_o)
  );

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      xstate_q <= '0;
      xcomp_q  <= '0;
    end else if (accept) begin
      base_q   <= base_i;
      xstate_q <= xstate_c;
      xcomp_q  <= xcomp_c;
    end
  end

  always_comb begin
    wr_en_o   = 1'b1;
    wr_addr_o = base_q;
    wr_data_o = '0;
    case (kind)
      WK_COMP: begin
        wr_addr_o = base_q + ADDR_W'(comp_off(int'(rd_sel_o)))
                           + (ADDR_W'(rd_beat_o) << 3);
        wr_data_o = rd_data_i;
      end
      WK_XSTATE: begin
        wr_addr_o = base_q + ADDR_W'(HDR_OFF);
        wr_data_o = xstate_q;
      end
      WK_XCOMP: begin
        wr_addr_o = base_q + ADDR_W'(HCOMP_OFF);
        wr_data_o = xcomp_q;
      end
      default: wr_en_o = 1'b0;
    endcase
  end

  assign off = wr_addr_o - base_q;

  // R5
  xcomp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WK_XCOMP) |-> (wr_en_o && wr_data_o[63]));
  // R4
  xstate_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WK_XSTATE) |-> ((wr_data_o & ~xcomp_q) == 64'd0));
  // R2
  saved_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WK_COMP && rd_sel_o != 2'd1) |-> xstate_q[rd_sel_o]);
  // R3
  sse_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == WK_COMP && rd_sel_o == 2'd1) |-> xcomp_q[1]);
  // R8
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !((off >= ADDR_W'(GAP_LO) && off < ADDR_W'(HDR_OFF)) ||
                  (off >= ADDR_W'(HDR_END) && off < ADDR_W'(EXT_OFF))));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(base_q) && $stable(xcomp_q) && $stable(xstate_q)));
endmodule

// File: tb/xsv_save_seq_test.sv
module xsv_save_seq_test;
  localparam int AW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   mhi = '0, mlo = '0, fen = '0, iu = '0;
  logic [31:0]   mx = 32'h1F80;
  logic [AW-1:0] base = '0;
  logic [1:0]    rsel;
  logic [5:0]    rbeat;
  logic [63:0]   rdata;
  logic          wen;
  logic [AW-1:0] waddr;
  logic [63:0]   wdata;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [AW-1:0] exp_a [0:127];
  logic [63:0]   exp_d [0:127];
  int            exp_n;
  logic [AW-1:0] act_a [0:127];
  logic [63:0]   act_d [0:127];
  int            act_n;

  always #5 clk = ~clk;

  function automatic logic [63:0] pat(int sel, int beat);
    return {8'(sel), 8'(beat), 48'h5EED_0BAD_F00D};
  endfunction

  assign rdata = pat(int'(rsel), int'(rbeat));

  xsv_save_seq #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mask_hi_i(mhi), .mask_lo_i(mlo), .feat_en_i(fen), .in_use_i(iu),
    .mxcsr_i(mx), .base_i(base),
    .rd_sel_o(rsel), .rd_beat_o(rbeat), .rd_data_i(rdata),
    .wr_en_o(wen), .wr_addr_o(waddr), .wr_data_o(wdata),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [AW-1:0] a, logic [63:0] d);
    exp_a[exp_n] = a;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  // build the expected write list from the requirements, run one operation, compare
  task automatic run_op(string req, logic [63:0] h, logic [63:0] l, logic [63:0] en,
                        logic [63:0] u, logic [31:0] m, logic [AW-1:0] b, bit poke);
    logic [63:0] rq;
    bit s0, s1, s2;
    int k, done_k;
    rq = en & {h[31:0], l[31:0]};
    s0 = rq[0] & u[0];
    s1 = rq[1] & (u[1] | (m != 32'h1F80));
    s2 = rq[2] & u[2];
    exp_n = 0;
    if (s0) for (int i = 0; i < 20; i++) push(b + AW'(8 * i), pat(0, i));
    if (s1) for (int i = 0; i < 32; i++) push(b + AW'(160 + 8 * i), pat(1, i));
    if (s2) for (int i = 0; i < 32; i++) push(b + AW'(576 + 8 * i), pat(2, i));
    push(b + AW'(512), u & rq);
    push(b + AW'(520), {1'b1, rq[62:0]});

    @(negedge clk);
    mhi = h; mlo = l; fen = en; iu = u; mx = m; base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    act_n = 0; done_k = -1; k = 1;
    chk("R7", "busy after start", {63'd0, busy}, 64'd1);
    while (k < 300) begin
      if (wen) begin
        if (act_n < 128) begin
          act_a[act_n] = waddr;
          act_d[act_n] = wdata;
        end
        act_n++;
      end
      if (done) begin
        done_k = k;
        break;
      end
      if (poke && k == 3) begin
        // R9: new inputs and a second start mid-operation
        mhi = '1; mlo = '1; fen = '1; iu = '1; mx = 32'h0; base = b + AW'(4096); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      k++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(req, "write count", 64'(act_n), 64'(exp_n));
    chk("R7", "done cycle", 64'(done_k), 64'(exp_n + 1));
    for (int i = 0; i < exp_n && i < act_n; i++) begin
      chk(req, $sformatf("addr[%0d]", i), 64'(act_a[i]), 64'(exp_a[i]));
      chk(req, $sformatf("data[%0d]", i), act_d[i], exp_d[i]);
      if ((act_a[i] - b) >= AW'(464) && (act_a[i] - b) < AW'(512))
        chk("R8", "legacy gap write", 64'(act_a[i]), 64'd0);
    end
    @(negedge clk);
    chk("R7", "done width", {63'd0, done}, 64'd0);
    chk("R7", "busy cleared", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R7", "reset wr_en", {63'd0, wen}, 64'd0);
    chk("R7", "reset done", {63'd0, done}, 64'd0);
    chk("R7", "reset busy", {63'd0, busy}, 64'd0);
  endtask

  task automatic t_all();      // R6 R4 R5: all three components
    run_op("R6", 64'h0, 64'h7, 64'h7, 64'h7, 32'h1F80, 48'h1000, 0);
  endtask

  task automatic t_ext_only(); // R2: only component 2 in use
    run_op("R2", 64'h0, 64'h7, 64'h7, 64'h4, 32'h1F80, 48'h2040, 0);
  endtask

  task automatic t_x87_only(); // R2: component 2 in use but not requested
    run_op("R2", 64'h0, 64'h1, 64'hFF, 64'h7, 32'h1F80, 48'h3000, 0);
  endtask

  task automatic t_upper();    // R1: upper halves of mask registers ignored
    run_op("R1", 64'hFFFF_FFFF_0000_0010, 64'hFFFF_FFFF_0000_0001,
           64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1F80, 48'h4000, 0);
  endtask

  task automatic t_sse_override(); // R3: control word forces SSE, header bit stays 0
    run_op("R3", 64'h0, 64'h2, 64'h7, 64'h0, 32'h0000_1FC0, 48'h5000, 0);
    run_op("R3", 64'h0, 64'h2, 64'h7, 64'h0, 32'h0000_1F80, 48'h5000, 0);
  endtask

  task automatic t_empty();    // R5: nothing requested, header only
    run_op("R5", 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7, 32'h0, 48'h6000, 0);
  endtask

  task automatic t_high_bit(); // R5 R1: request bit 40 and bit 63 handling
    run_op("R5", 64'h8000_0100, 64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0100_0000_0001,
           32'h1F80, 48'h7000, 0);
  endtask

  task automatic t_busy_start(); // R9
    run_op("R9", 64'h0, 64'h3, 64'h3, 64'h3, 32'h1F80, 48'h8000, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_all();
    t_ext_only();
    t_x87_only();
    t_upper();
    t_sse_override();
    t_empty();
    t_high_bit();
    t_busy_start();
    finished = 1;
    summary();
    $finish;
  end
endmodule